// File: doc/BRIEF.md
# SPI Master Controller with Byte Queues

This block is a memory-mapped SPI master. Software talks to it through 32-bit word-aligned reads and writes. Bytes written to the transmit data register are placed in a transmit queue. Whenever the transfer-hold bit in the control register is clear, the controller takes bytes from the queue one at a time. It shifts each byte out on `mosi` with a divided serial clock and captures the reply from `miso` into a receive queue, which software reads back through the receive data register. Both queues are byte wide and parameterised in depth, with a default of 256 entries.

Device selection is left to software. Each active-low select output copies one bit of a select register, so software frames a transaction by writing that register around its data bytes. When a received byte finds the receive queue full, the byte is dropped. Two single-cycle pulses go to an external interrupt block: one for a dropped byte, and one for the moment the receive queue fills. A separate reset register restarts the whole controller, but only when the write carries a fixed key.

The word offsets that decode registers are: reset 0x40, control 0x60, status 0x64, transmit data 0x68, receive data 0x6C, select 0x70, transmit occupancy 0x74 and receive occupancy 0x78. Any other offset reads as 0, and writes to it are ignored.

Top module: `spi_byte_master`

## Requirements
- R1: A bus access is taken only when all four byte enables are set. Any other access has no effect and produces no `bus_rvalid`. Offsets not listed in the map read as 0.
- R2: After reset the control register reads 0x00000100 and the select register reads 0xFFFFFFFF. The status register reads 0x5, both occupancy registers read 0, every `cs_n` is 1 and `sck` is 0.
- R3: Control bit 8 is the hold bit: while it is 1, no new byte transfer starts. Writing control with bit 5 set empties the transmit queue, and writing it with bit 6 set empties the receive queue. Bits 5 and 6 always read back as 0.
- R4: Status bit 0 is receive-empty, bit 1 is receive-full, bit 2 is transmit-empty and bit 3 is transmit-full. The other status bits read 0, and writes to status change nothing.
- R5: A write of 0x0000000A to the reset register returns every register and both queues to their reset state. A write of any other value there has no effect.
- R6: `cs_n[i]` equals bit i of the select register, so writing a 0 to that bit drives the select low.
- R7: A transmit-data write queues bits 7:0 of the written word. A write while the transmit queue holds DEPTH bytes is discarded. The occupancy registers report each queue's entry count, 0 to DEPTH.
- R8: While the hold bit is 0, queued bytes are sent back to back until the transmit queue is empty. Each byte is 8 bits, MSB first, in SPI mode 0: `sck` idles low and `mosi` changes while `sck` is low. Each `sck` level lasts HALF_DIV clock cycles.
- R9: `miso` is sampled on each rising `sck` edge. A completed byte is pushed into the receive queue. If that queue is full in the completion cycle, the byte is dropped and `ev_rx_overrun` pulses for one cycle. If the push makes the queue full, `ev_rx_full` pulses for one cycle.
- R10: A read of receive data pops and returns the oldest byte in bits 7:0, with the upper bits 0. When the receive queue is empty, the read returns 0xDEADBEEF and no state changes.
- R11: `bus_rvalid` is 1 in exactly the cycle after an accepted read, and `bus_rdata` holds the read value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | 4 | Byte enables; all four must be set for the access to be taken |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low device selects |
| ev_rx_overrun | output | 1 | Pulse: received byte dropped |
| ev_rx_full | output | 1 | Pulse: receive queue just became full |

## Verification
A software pop of the receive queue and the completion of an incoming byte can happen in the same clock cycle. The bench provokes this by leaving bytes in the receive queue and then streaming a long burst of transfers while reading at a cadence one cycle longer than the byte period. Because the two periods differ by one cycle, the read slides across every phase of a byte, including its completion cycle. The check is that every byte comes back exactly once, in order, with the expected reply values, and that no overrun pulse appears.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam logic [6:0] OFS_SWRST = 7'h40;
  localparam logic [6:0] OFS_CTRL  = 7'h60;
  localparam logic [6:0] OFS_STAT  = 7'h64;
  localparam logic [6:0] OFS_TXD   = 7'h68;
  localparam logic [6:0] OFS_RXD   = 7'h6C;
  localparam logic [6:0] OFS_SSEL  = 7'h70;
  localparam logic [6:0] OFS_TXOCC = 7'h74;
  localparam logic [6:0] OFS_RXOCC = 7'h78;

  localparam int CTRL_TXCLR = 5;
  localparam int CTRL_RXCLR = 6;
  localparam int CTRL_HOLD  = 8;

  localparam logic [31:0] SWRST_KEY  = 32'h0000_000A;
  localparam logic [31:0] EMPTY_WORD = 32'hDEAD_BEEF;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0100;

  typedef enum logic [1:0] {SH_IDLE, SH_LOAD, SH_BIT} sh_state_e;
endpackage

// File: rtl/spi_bm_fifo.sv
module spi_bm_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // storage and registered read port, no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter
  import spi_bm_pkg::*;
#(
  parameter int HALF_DIV = 4,
  localparam int DCW     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  output logic       tx_pop,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  sh_state_e      st;
  logic [DCW-1:0] div_cnt;
  logic [2:0]     bit_cnt;
  logic [7:0]     tx_sh, rx_sh;
  logic           sck_q, done_q;
  logic           tick;

  assign tick     = (div_cnt == DCW'(HALF_DIV - 1));
  assign tx_pop   = (st == SH_IDLE) && go;
  assign sck      = sck_q;
  assign mosi     = tx_sh[7];
  assign rx_valid = done_q;
  assign rx_byte  = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SH_IDLE;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        SH_IDLE: if (go) st <= SH_LOAD;
        SH_LOAD: begin
          tx_sh   <= tx_byte;
          div_cnt <= '0;
          bit_cnt <= '0;
          sck_q   <= 1'b0;
          st      <= SH_BIT;
        end
        SH_BIT: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_sh <= {rx_sh[6:0], miso};
            end else begin
              sck_q <= 1'b0;
              if (bit_cnt == 3'd7) begin
                st     <= SH_IDLE;
                done_q <= 1'b1;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                tx_sh   <= {tx_sh[6:0], 1'b0};
              end
            end
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int NUM_CS   = 1,
  parameter int DEPTH    = 256,
  parameter int HALF_DIV = 4,
  parameter int ADDR_W   = 7,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              ev_rx_overrun,
  output logic              ev_rx_full
);
  logic          wr_acc, rd_acc;
  logic [6:0]    ofs;
  logic          srst_q, rst_i;
  logic [31:0]   ctrl_q, ss_q;
  logic          ss_wr, tx_clr, rx_clr, tx_push, rx_pop, rx_push;
  logic          go, sh_pop, sh_done;
  logic [7:0]    tx_dout, rx_dout, sh_rx_byte;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic          rvalid_q, sel_rx_q, ovr_q, fullev_q;
  logic [31:0]   hold_q, rd_mux;

  assign wr_acc = bus_wr && (&bus_be);
  assign rd_acc = bus_rd && (&bus_be);
  assign ofs    = 7'(bus_addr);
  assign rst_i  = rst || srst_q;

  assign ss_wr   = wr_acc && (ofs == OFS_SSEL);
  assign tx_clr  = wr_acc && (ofs == OFS_CTRL) && bus_wdata[CTRL_TXCLR];
  assign rx_clr  = wr_acc && (ofs == OFS_CTRL) && bus_wdata[CTRL_RXCLR];
  assign tx_push = wr_acc && (ofs == OFS_TXD);
  assign rx_pop  = rd_acc && (ofs == OFS_RXD) && !rx_empty;
  assign rx_push = sh_done && !rx_clr;
  assign go      = !ctrl_q[CTRL_HOLD] && !tx_empty && !tx_clr;

  // keyed restart: registered so the reset fan-out starts from a flop
  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= wr_acc && (ofs == OFS_SWRST) && (bus_wdata == SWRST_KEY);
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      ctrl_q <= CTRL_RESET;
      ss_q   <= '1;
    end else begin
      if (wr_acc && (ofs == OFS_CTRL))
        ctrl_q <= bus_wdata & ~((32'd1 << CTRL_TXCLR) | (32'd1 << CTRL_RXCLR));
      if (ss_wr) ss_q <= bus_wdata;
    end
  end

  assign cs_n = ss_q[NUM_CS-1:0];

  spi_bm_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst(rst_i), .clr(tx_clr),
    .push(tx_push), .din(bus_wdata[7:0]),
    .pop(sh_pop), .dout(tx_dout),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  spi_bm_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst(rst_i), .clr(rx_clr),
    .push(rx_push), .din(sh_rx_byte),
    .pop(rx_pop), .dout(rx_dout),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  spi_bm_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst_i), .go(go),
    .tx_pop(sh_pop), .tx_byte(tx_dout),
    .miso(miso), .sck(sck), .mosi(mosi),
    .rx_valid(sh_done), .rx_byte(sh_rx_byte)
  );

  // receive-side events judged on occupancy at the start of the cycle
  always_ff @(posedge clk) begin
    if (rst_i) begin
      ovr_q    <= 1'b0;
      fullev_q <= 1'b0;
    end else begin
      ovr_q    <= rx_push && rx_full;
      fullev_q <= rx_push && !rx_full && !rx_pop && (rx_cnt == CW'(DEPTH - 1));
    end
  end

  assign ev_rx_overrun = ovr_q;
  assign ev_rx_full    = fullev_q;

  always_comb begin
    case (ofs)
      OFS_CTRL:  rd_mux = ctrl_q;
      OFS_STAT:  rd_mux = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
      OFS_SSEL:  rd_mux = ss_q;
      OFS_TXOCC: rd_mux = 32'(tx_cnt);
      OFS_RXOCC: rd_mux = 32'(rx_cnt);
      OFS_RXD:   rd_mux = rx_empty ? EMPTY_WORD : 32'd0;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      rvalid_q <= 1'b0;
      sel_rx_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      rvalid_q <= rd_acc;
      sel_rx_q <= rx_pop;
      if (rd_acc) hold_q <= rd_mux;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = sel_rx_q ? {24'd0, rx_dout} : hold_q;
endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker #(
  parameter int NUM_CS = 1,
  parameter int DEPTH  = 256,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_acc,
  input logic              rvalid,
  input logic              srst,
  input logic              ss_wr,
  input logic [NUM_CS-1:0] cs_n,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              ev_ovr,
  input logic              ev_full
);
  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && !srst) |=> rvalid); // R11
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> !rvalid); // R11
  AST_OVERRUN_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    ev_ovr |-> ($past(rx_cnt) == CW'(DEPTH))); // R9
  AST_FULL_EVENT_AT_DEPTH: assert property (@(posedge clk) disable iff (rst)
    ev_full |-> (rx_cnt == CW'(DEPTH))); // R9
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ev_ovr && ev_full)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH))); // R7
  AST_CS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ss_wr && !srst) |=> $stable(cs_n)); // R6
endmodule

bind spi_byte_master spi_bm_checker #(.NUM_CS(NUM_CS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rd_acc(rd_acc), .rvalid(bus_rvalid), .srst(srst_q),
  .ss_wr(ss_wr), .cs_n(cs_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .ev_ovr(ev_rx_overrun), .ev_full(ev_rx_full)
);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCS  = 2;
  localparam int DEP  = 256;
  localparam int HALF = 2;
  localparam logic [6:0] A_RST = 7'h40, A_CTRL = 7'h60, A_STAT = 7'h64, A_TXD = 7'h68,
                         A_RXD = 7'h6C, A_SSEL = 7'h70, A_TXOCC = 7'h74, A_RXOCC = 7'h78;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [6:0] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, sck, mosi, miso, ev_rx_overrun, ev_rx_full;
  logic [NCS-1:0] cs_n;

  int n_tests = 0, n_fail = 0;
  int ovr_cnt = 0, full_cnt = 0, rises = 0, cyc = 0, last_rise = 0, first_gap = 0;
  int gidx = 0, log_n = 0, bitc = 0, slv_idx = 0;
  logic [7:0] exp_tx [2048];
  logic [7:0] mosi_log [2048];
  logic [7:0] slv_sh, mosi_sh;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master #(.NUM_CS(NCS), .DEPTH(DEP), .HALF_DIV(HALF), .ADDR_W(7)) u_spi_byte_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .ev_rx_overrun(ev_rx_overrun), .ev_rx_full(ev_rx_full)
  );

  function automatic logic [7:0] resp(input int k);
    return 8'((k * 37 + 5) % 256);
  endfunction

  // slave model: mode 0, replies resp(k) for the k-th byte
  initial slv_sh = resp(0);
  assign miso = slv_sh[7];
  always @(posedge sck) begin
    mosi_sh = {mosi_sh[6:0], mosi};
    rises++;
    if (rises == 2) first_gap = cyc - last_rise;
    last_rise = cyc;
  end
  always @(negedge sck) begin
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      mosi_log[log_n] = mosi_sh;
      log_n++;
      slv_idx++;
      slv_sh = resp(slv_idx);
    end else slv_sh = {slv_sh[6:0], 1'b0};
  end

  always @(posedge clk) begin
    cyc++;
    if (ev_rx_overrun) ovr_cnt++;
    if (ev_rx_full) full_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = 4'hF;
  endtask

  task automatic rd32(input logic [6:0] a, output logic [31:0] d, output logic v,
                      input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_rd = 0; bus_be = 4'hF;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic rchk(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd32(a, d, v);
    chk({req, " rvalid"}, {31'd0, v}, 32'd1);
    chk(req, d, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] d; logic v;
    for (int k = 0; k < 20000; k++) begin
      rd32(A_TXOCC, d, v);
      if (d == 0) break;
    end
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d; logic v; logic [7:0] b;
    int base, mism, got, o0, f0;
    logic [7:0] gotb [64];
    void'($urandom(32'd7315));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 cs_n reset", 32'(cs_n), 32'h3);
    chk("R2 sck reset", 32'(sck), 32'h0);
    rchk("R2 ctrl reset", A_CTRL, 32'h100);
    rchk("R2 ssel reset", A_SSEL, 32'hFFFF_FFFF);
    rchk("R2 R4 status reset", A_STAT, 32'h5);
    rchk("R2 txocc reset", A_TXOCC, 0);
    rchk("R2 rxocc reset", A_RXOCC, 0);
    rchk("R1 unmapped offset", 7'h10, 0);

    // held: bytes queue, no clocks
    wr32(A_TXD, 32'h1234_56A5); exp_tx[0] = 8'hA5;
    wr32(A_TXD, 32'h0000_003C); exp_tx[1] = 8'h3C;
    b = 8'($urandom); wr32(A_TXD, {24'hFFFFFF, b}); exp_tx[2] = b;
    repeat (100) @(negedge clk);
    chk("R3 no sck while held", rises, 0);
    rchk("R7 txocc three", A_TXOCC, 3);
    rchk("R4 status tx nonempty", A_STAT, 32'h1);
    wr32(A_STAT, 32'hFFFF_FFFF);
    rchk("R4 status write ignored", A_STAT, 32'h1);

    wr32(A_CTRL, 32'h0);
    wait_idle();
    chk("R8 sck rises for three bytes", rises, 24);
    chk("R8 sck period", first_gap, 2 * HALF);
    rchk("R9 rxocc three", A_RXOCC, 3);
    for (int i = 0; i < 3; i++) rchk("R10 rx pop value", A_RXD, {24'd0, resp(i)});
    gidx = 3;
    rchk("R10 empty read key", A_RXD, 32'hDEAD_BEEF);
    rchk("R10 empty read no change", A_RXOCC, 0);
    rchk("R4 status idle", A_STAT, 32'h5);

    // random bursts
    for (int it = 0; it < 20; it++) begin
      int n;
      n = $urandom_range(1, 5);
      for (int j = 0; j < n; j++) begin
        b = 8'($urandom);
        exp_tx[gidx + j] = b;
        wr32(A_TXD, {$urandom} & 32'hFFFF_FF00 | {24'd0, b});
      end
      wait_idle();
      rchk("R9 rxocc burst", A_RXOCC, n);
      for (int j = 0; j < n; j++) rchk("R8 R10 burst reply", A_RXD, {24'd0, resp(gidx + j)});
      gidx += n;
    end

    // transmit full, then receive full and overrun
    wr32(A_CTRL, 32'h100);
    for (int i = 0; i < DEP; i++) begin
      b = 8'($urandom); exp_tx[gidx + i] = b; wr32(A_TXD, {24'd0, b});
    end
    wr32(A_TXD, 32'h77);
    rchk("R7 txocc at depth", A_TXOCC, DEP);
    rchk("R4 status tx full", A_STAT, 32'h9);
    o0 = ovr_cnt; f0 = full_cnt;
    wr32(A_CTRL, 32'h0);
    wait_idle();
    chk("R9 full event once", full_cnt - f0, 1);
    rchk("R9 rxocc full", A_RXOCC, DEP);
    rchk("R4 status rx full", A_STAT, 32'h6);
    b = 8'($urandom); exp_tx[gidx + DEP] = b; wr32(A_TXD, {24'd0, b});
    wait_idle();
    chk("R9 overrun event", ovr_cnt - o0, 1);
    rchk("R9 rxocc after overrun", A_RXOCC, DEP);
    base = gidx; gidx += DEP + 1; mism = 0;
    for (int i = 0; i < DEP; i++) begin
      rd32(A_RXD, d, v);
      if (d !== {24'd0, resp(base + i)}) mism++;
    end
    chk("R9 kept bytes in order", mism, 0);
    rchk("R9 dropped byte absent", A_RXD, 32'hDEAD_BEEF);

    // pop colliding with completion
    o0 = ovr_cnt;
    for (int i = 0; i < 10; i++) begin
      b = 8'($urandom); exp_tx[gidx + i] = b; wr32(A_TXD, {24'd0, b});
    end
    wait_idle();
    for (int i = 0; i < 30; i++) begin
      b = 8'($urandom); exp_tx[gidx + 10 + i] = b; wr32(A_TXD, {24'd0, b});
    end
    got = 0;
    for (int c = 0; c < 1400; c++) begin
      @(negedge clk);
      if (bus_rvalid && bus_rdata != 32'hDEAD_BEEF && got < 64) begin gotb[got] = bus_rdata[7:0]; got++; end
      bus_rd = (c % 35 == 0); bus_addr = A_RXD;
    end
    @(negedge clk); bus_rd = 0;
    if (bus_rvalid && bus_rdata != 32'hDEAD_BEEF && got < 64) begin gotb[got] = bus_rdata[7:0]; got++; end
    wait_idle();
    for (int k = 0; k < 40; k++) begin
      rd32(A_RXD, d, v);
      if (d == 32'hDEAD_BEEF) break;
      if (got < 64) begin gotb[got] = d[7:0]; got++; end
    end
    chk("R10 collision byte count", got, 40);
    mism = 0;
    for (int i = 0; i < 40; i++) if (i < got && gotb[i] !== resp(gidx + i)) mism++;
    chk("R10 collision order", mism, 0);
    chk("R9 no overrun in collision", ovr_cnt - o0, 0);
    gidx += 40;

    chk("R8 byte count on wire", log_n, gidx);
    mism = 0;
    for (int i = 0; i < gidx; i++) if (mosi_log[i] !== exp_tx[i]) mism++;
    chk("R8 mosi bytes MSB first", mism, 0);

    // queue clears
    wr32(A_CTRL, 32'h100);
    wr32(A_TXD, 32'h11); wr32(A_TXD, 32'h22);
    wr32(A_CTRL, 32'h120);
    rchk("R3 tx clear empties", A_TXOCC, 0);
    rchk("R3 clear bit reads 0", A_CTRL, 32'h100);
    b = 8'($urandom); exp_tx[gidx] = b; wr32(A_TXD, {24'd0, b});
    wr32(A_CTRL, 32'h0);
    wait_idle();
    gidx++;
    rchk("R9 rx one byte", A_RXOCC, 1);
    wr32(A_CTRL, 32'h140);
    rchk("R3 rx clear empties", A_RXOCC, 0);
    rchk("R3 rx clear status", A_STAT, 32'h5);
    rchk("R3 rx clear bit reads 0", A_CTRL, 32'h100);

    // selects and partial access
    wr32(A_SSEL, 32'hFFFF_FFFE);
    chk("R6 cs_n bit0 low", 32'(cs_n), 32'h2);
    wr32(A_SSEL, 32'h0000_0001);
    chk("R6 cs_n bit1 low", 32'(cs_n), 32'h1);
    rchk("R6 ssel readback", A_SSEL, 32'h1);
    wr32(A_SSEL, 32'h0, 4'h3);
    chk("R1 partial write ignored", 32'(cs_n), 32'h1);
    rd32(A_SSEL, d, v, 4'h3);
    chk("R1 partial read no rvalid", 32'(v), 0);

    // keyed restart
    wr32(A_TXD, 32'h5A); wr32(A_TXD, 32'h6B);
    wr32(A_SSEL, 32'h0);
    wr32(A_RST, 32'h5);
    @(negedge clk);
    rchk("R5 wrong key keeps txocc", A_TXOCC, 2);
    rchk("R5 wrong key keeps ssel", A_SSEL, 0);
    wr32(A_RST, 32'hA);
    @(negedge clk);
    rchk("R5 restart txocc", A_TXOCC, 0);
    rchk("R5 restart ssel", A_SSEL, 32'hFFFF_FFFF);
    rchk("R5 restart ctrl", A_CTRL, 32'h100);
    chk("R5 restart cs_n", 32'(cs_n), 32'h3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule